// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A memory-mapped watchdog built on a down counter that reloads from a programmable reload register. When the counter first runs out it raises an interrupt. The interrupt goes to either a standard line or a non-maskable line. If the counter runs out a second time while that interrupt is still uncleared, and reset generation is enabled, the block raises a sticky system reset request.

Software reaches the block through a small word-addressed register bus. Writes take effect on the clock edge. Read data is combinational on the address.

A lock register can freeze the configuration. While it is locked, writes to control, reload, interrupt-clear and stall are ignored. A debug-halt input can freeze the counter while the processor is stopped, but only if stalling has been enabled.

Register offsets (`bus_addr`):

| Offset | Register | Access |
|---|---|---|
| 0 | reload | read/write |
| 1 | current count | read-only |
| 2 | control | read/write |
| 3 | interrupt clear | write, any data |
| 4 | raw status | read-only |
| 5 | masked status | read-only |
| 6 | stall control | read/write |
| 7 | lock | read/write |

Control bits:

| Bit | Function |
|---|---|
| 0 | run (interrupt enable) |
| 1 | reset enable |
| 2 | interrupt type: 0 standard, 1 non-maskable |

Top module: `wdog_twostage`

## Requirements
- R1: After reset, reload (offset 0) reads 0xFFFFFFFF. Control (offset 2), raw status (offset 4) and lock (offset 7) read 0. `irq`, `nmi` and `sys_rst` are low.
- R2: Writing control bit 0 = 1 while the block is stopped loads the count from the reload register and starts counting. Control bit 0 reads back as the running state. Writing 0 to that bit afterwards leaves it at 1. While the block is stopped, the count does not change.
- R3: If the count is N after a clock edge, the (N+1)-th following edge finds a zero count. On that edge raw status (offset 4, bit 0) sets and the count reloads from the reload register.
- R4: An expiry with raw status already set and control bit 1 = 1 sets `sys_rst`. `sys_rst` then stays high until `rst_n` is asserted. If control bit 1 = 0, a second expiry does not raise `sys_rst`.
- R5: Any write to offset 3 clears raw status and reloads the count from the reload register. If that write falls on the same edge as an expiry, the clear wins: raw status ends at 0 and `sys_rst` stays low.
- R6: A write to offset 0 stores the value and copies it into the count on the same edge. A value of 0 causes an expiry on the next edge while the block is running.
- R7: Writing 0x1ACCE551 to offset 7 unlocks the block. Writing any other value locks it. Offset 7 reads 1 when locked and 0 when unlocked. While locked, writes to offsets 0, 2, 3 and 6 are ignored.
- R8: With stall bit 0 (offset 6) set and `dbg_halt` high, the count holds its value. With the stall bit clear, the count keeps decrementing while `dbg_halt` is high.
- R9: Masked status (offset 5) equals raw status ANDed with the running bit. It drives `irq` when control bit 2 = 0 and `nmi` when control bit 2 = 1. The other of the two lines stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_wr | input | 1 | write strobe |
| bus_addr | input | 3 | word register offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational on bus_addr |
| dbg_halt | input | 1 | processor halted by debugger |
| irq | output | 1 | standard interrupt |
| nmi | output | 1 | non-maskable interrupt |
| sys_rst | output | 1 | sticky system reset request |

## Verification
An interrupt-clear write can land on the same edge as the second expiry, and the two events have opposite intent. The bench waits for the first interrupt with reset enabled. It then times the clear write exactly onto the edge where the count hits zero again. It checks that raw status ends cleared, `sys_rst` stays low and the next interrupt arrives one full period later. A companion run without the clear confirms that the same edge would otherwise have raised `sys_rst`.

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int W = 32,
  parameter logic [31:0] KEY = 32'h1ACCE551
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         dbg_halt,
  output logic         irq,
  output logic         nmi,
  output logic         sys_rst
);
  localparam logic [2:0] A_LOAD = 3'd0, A_CNT = 3'd1, A_CTRL = 3'd2, A_CLR = 3'd3,
                         A_RAW = 3'd4, A_MSK = 3'd5, A_STALL = 3'd6, A_LOCK = 3'd7;

  logic [W-1:0] load_q, cnt_q;
  logic en_q, rst_en_q, nmi_sel_q, stall_q, locked_q, raw_q;

  wire wr_ok  = bus_wr && !locked_q;
  wire clr    = wr_ok && bus_addr == A_CLR;
  wire ld     = wr_ok && bus_addr == A_LOAD;
  wire start  = wr_ok && bus_addr == A_CTRL && bus_wdata[0] && !en_q;
  wire tick   = en_q && !(stall_q && dbg_halt);
  wire masked = raw_q && en_q;

  assign irq = masked && !nmi_sel_q;
  assign nmi = masked && nmi_sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q    <= '1;
      cnt_q     <= '1;
      en_q      <= 1'b0;
      rst_en_q  <= 1'b0;
      nmi_sel_q <= 1'b0;
      stall_q   <= 1'b0;
      locked_q  <= 1'b0;
      raw_q     <= 1'b0;
      sys_rst   <= 1'b0;
    end else begin
      if (wr_ok && bus_addr == A_CTRL) begin
        en_q      <= en_q | bus_wdata[0];
        rst_en_q  <= bus_wdata[1];
        nmi_sel_q <= bus_wdata[2];
      end
      if (wr_ok && bus_addr == A_STALL) stall_q <= bus_wdata[0];
      if (bus_wr && bus_addr == A_LOCK) locked_q <= (bus_wdata[31:0] != KEY);
      if (ld) load_q <= bus_wdata;
      if (clr) begin
        raw_q <= 1'b0;
        cnt_q <= load_q;
      end else if (ld) begin
        cnt_q <= bus_wdata;
      end else if (start) begin
        cnt_q <= load_q;
      end else if (tick) begin
        if (cnt_q == '0) begin
          cnt_q <= load_q;
          raw_q <= 1'b1;
          if (raw_q && rst_en_q) sys_rst <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LOAD:  bus_rdata = load_q;
      A_CNT:   bus_rdata = cnt_q;
      A_CTRL:  bus_rdata[2:0] = {nmi_sel_q, rst_en_q, en_q};
      A_RAW:   bus_rdata[0] = raw_q;
      A_MSK:   bus_rdata[0] = masked;
      A_STALL: bus_rdata[0] = stall_q;
      A_LOCK:  bus_rdata[0] = locked_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(parameter int W = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [2:0]   bus_addr,
  input logic         dbg_halt,
  input logic         irq,
  input logic         nmi,
  input logic         sys_rst,
  input logic         en_q,
  input logic         rst_en_q,
  input logic         stall_q,
  input logic         locked_q,
  input logic         raw_q,
  input logic [W-1:0] load_q,
  input logic [W-1:0] cnt_q
);
  p_rst_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> sys_rst);
  p_rst_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(raw_q) && $past(rst_en_q));
  p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  p_lock_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && bus_wr && bus_addr == 3'd0 |=> $stable(load_q));
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && stall_q && dbg_halt && !(bus_wr && !locked_q) |=> $stable(cnt_q));
  p_one_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && nmi));
endmodule

bind wdog_twostage wdog_twostage_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .dbg_halt(dbg_halt), .irq(irq), .nmi(nmi), .sys_rst(sys_rst),
  .en_q(en_q), .rst_en_q(rst_en_q), .stall_q(stall_q), .locked_q(locked_q),
  .raw_q(raw_q), .load_q(load_q), .cnt_q(cnt_q));

// File: tb/wdog_twostage_bench.sv
module wdog_twostage_bench;
  logic clk = 0, rst_n = 0, bus_wr = 0, dbg_halt = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, nmi, sys_rst;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  wdog_twostage u_wdog_twostage (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bus_wr = 0; dbg_halt = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // which: 0 irq, 1 nmi, 2 sys_rst
  task automatic wait_sig(int which, output int k);
    k = 0;
    for (int i = 0; i < 2000; i++) begin
      if ((which == 0 && irq) || (which == 1 && nmi) || (which == 2 && sys_rst)) break;
      step(1); k++;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int k;
    do_reset();
    // R1
    rd(3'd0, v); check("R1 reload", v, 32'hFFFFFFFF);
    rd(3'd2, v); check("R1 ctrl", v, 0);
    rd(3'd4, v); check("R1 raw", v, 0);
    rd(3'd7, v); check("R1 lock", v, 0);
    check("R1 outs", {irq, nmi, sys_rst}, 0);

    // R3 R5 R6 sweep of reload values
    for (int n = 0; n < 6; n++) begin
      do_reset();
      wr(3'd2, 1);
      wr(3'd0, n);
      wait_sig(0, k);
      check($sformatf("R6 R3 period n=%0d", n), k, n + 1);
      check("R9 irq only", {irq, nmi}, 2'b10);
      rd(3'd4, v); check("R3 raw", v, 1);
      wr(3'd3, 0);
      rd(3'd4, v); check("R5 clear", v, 0);
      wait_sig(0, k);
      check($sformatf("R5 reload period n=%0d", n), k, n + 1);
      step(n + 2);
      check("R4 no reset when disabled", sys_rst, 0);
    end

    // R2
    do_reset();
    wr(3'd0, 4);
    rd(3'd1, v); step(3); rd(3'd1, v2);
    check("R2 stopped holds", v2, v);
    wr(3'd2, 1);
    rd(3'd1, v); check("R2 start from reload", v, 4);
    rd(3'd2, v); check("R2 run bit", v[0], 1);
    wr(3'd2, 0);
    rd(3'd2, v); check("R2 run sticky", v[0], 1);

    // R4
    do_reset();
    wr(3'd2, 3); wr(3'd0, 3);
    wait_sig(0, k);
    wait_sig(2, k);
    check("R4 second expiry reset", k, 4);
    wr(3'd3, 0); step(5);
    check("R4 reset sticky", sys_rst, 1);

    // R5 collision: clear on the same edge as second expiry
    do_reset();
    wr(3'd2, 3); wr(3'd0, 3);
    wait_sig(0, k);
    step(3);
    wr(3'd3, 0);
    check("R5 clear beats expiry sys_rst", sys_rst, 0);
    rd(3'd4, v); check("R5 clear beats expiry raw", v, 0);
    wait_sig(0, k);
    check("R5 period after collision", k, 4);

    // R7
    do_reset();
    wr(3'd2, 1); wr(3'd0, 2);
    wait_sig(0, k);
    wr(3'd7, 0);
    rd(3'd7, v); check("R7 locked", v, 1);
    wr(3'd0, 9);
    rd(3'd0, v); check("R7 load ignored", v, 2);
    wr(3'd3, 0);
    rd(3'd4, v); check("R7 clear ignored", v, 1);
    wr(3'd2, 7);
    rd(3'd2, v); check("R7 ctrl ignored", v, 1);
    wr(3'd7, 32'h1ACCE551);
    rd(3'd7, v); check("R7 unlocked", v, 0);
    wr(3'd3, 0);
    rd(3'd4, v); check("R7 clear after unlock", v, 0);

    // R8
    do_reset();
    wr(3'd2, 1); wr(3'd0, 100); wr(3'd6, 1);
    dbg_halt = 1;
    rd(3'd1, v); step(5); rd(3'd1, v2);
    check("R8 stall holds", v2, v);
    wr(3'd6, 0);
    rd(3'd1, v); step(5); rd(3'd1, v2);
    check("R8 no stall counts", v2, v - 5);
    dbg_halt = 0;

    // R9
    do_reset();
    rd(3'd5, v); check("R9 masked idle", v, 0);
    wr(3'd2, 5); wr(3'd0, 1);
    wait_sig(1, k);
    check("R9 nmi period", k, 2);
    check("R9 nmi only", {irq, nmi}, 2'b01);
    rd(3'd5, v); check("R9 masked", v, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule